// File: doc/BRIEF.md
# Clock Generator Power-Up Sequencer

This block takes a clock generator from power-off to normal running through four steps. Its inputs are a digital supply-valid flag, which stands in for the analog supply comparator, an active-low power-good strobe and a strap bus that selects the output frequency. When the supply becomes valid, the sequencer enables the oscillator and waits for power-good. Power-good then starts a fixed delay. At the end of that delay the straps are captured. A settling interval follows, and only then are the clock outputs allowed to run.

Power-good is honoured once per power-up. Its first high-to-low transition starts the sequence. Later toggles on that pin have no effect until the supply-valid flag drops, which returns everything to the off state and re-arms the detector. Both delays are given in microseconds and converted to reference-clock cycles from a frequency parameter in kHz, rounding up.

The state is reported on a 2-bit port: 0 is off, 1 is waiting or delaying, 2 is sampling or settling, and 3 is running. The power-good pin is synchronized by a two-flop chain before edge detection, so it is recognized two cycles after it changes.

Top module: `clkgen_powerup_seq`

## Requirements
- R1: While reset is asserted, state_o is 0, and osc_en_o, out_en_o and fs_sel_o are all 0.
- R2: The machine leaves state 0 only when supply_ok_i is high. The cycle after it sees supply_ok_i high, state_o is 1 and osc_en_o is 1. Activity on pwrgd_n_i has no effect while supply_ok_i is low.
- R3: While pwrgd_n_i stays high, the machine remains in state 1 with out_en_o at 0 for as long as the supply stays valid.
- R4: State 2 is entered no earlier than PG_CYC and no later than PG_CYC+5 clock cycles after pwrgd_n_i falls. PG_CYC equals ceil(REF_KHZ*250/1000).
- R5: fs_sel_o takes the value of fs_strap_i from the last cycle spent in state 1. It then holds that value while the supply stays valid, whatever the straps do later.
- R6: State 2 lasts exactly SETTLE_CYC cycles, where SETTLE_CYC equals ceil(REF_KHZ*1146/1000). The machine then moves to state 3 and stays there while the supply is valid.
- R7: out_en_o is 0 in states 0, 1 and 2, and is 1 in state 3.
- R8: After the first recognized fall of pwrgd_n_i, further toggles of that pin change neither the state, nor out_en_o, nor fs_sel_o. This includes toggles during the power-good delay.
- R9: If supply_ok_i is low in any state, then in the next cycle state_o is 0 and osc_en_o, out_en_o and fs_sel_o are 0. The power-good detector is re-armed, so a new power-up needs a new power-good low.
- R10: If pwrgd_n_i is already low when supply_ok_i rises, this counts as the power-good fall. State 2 then follows within PG_CYC to PG_CYC+5 cycles of the supply rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Analog supply has reached its threshold (synchronous) |
| pwrgd_n_i | input | 1 | Active-low power-good strobe (asynchronous) |
| fs_strap_i | input | FS_W | Frequency-select straps |
| fs_sel_o | output | FS_W | Captured frequency-select word |
| osc_en_o | output | 1 | Oscillator enable, high in every state except 0 |
| out_en_o | output | 1 | Clock output enable |
| state_o | output | 2 | Sequencer state: 0 off, 1 wait, 2 sample/settle, 3 run |

## Verification
The bench toggles power-good during the startup delay and again in the running state. A design that restarts on a later edge would stretch the delay beyond its window, or fall back out of state 3. It changes the straps on the first settling cycle, which catches a design that samples late or keeps tracking the pins. It drops the supply in the middle of the settling interval and then powers up with power-good held high, to expose a detector that is not re-armed or a select word that is not cleared. It also powers up with power-good already low, which a pure edge detector would never see.

// File: rtl/clkseq_pkg.sv
`timescale 1ns/1ps
package clkseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

    // Convert a duration in microseconds to reference cycles, rounding up.
    function automatic int us_to_cycles(input int khz, input int us);
        return (khz * us + 999) / 1000;
    endfunction

endpackage

// File: rtl/clkseq_sync.sv
`timescale 1ns/1ps
module clkseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkseq_fall_once.sv
`timescale 1ns/1ps
module clkseq_fall_once (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rearm_i,
    output logic fired_o
);
    typedef struct packed {
        logic armed;
        logic hist;
        logic fired;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        if (rearm_i) begin
            // history forced high: a level already low counts as a fall
            det_d.armed = 1'b1;
            det_d.hist  = 1'b1;
            det_d.fired = 1'b0;
        end else begin
            if (det_q.armed && det_q.hist && !level_i) begin
                det_d.armed = 1'b0;
                det_d.fired = 1'b1;
            end
            det_d.hist = level_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '{armed: 1'b1, hist: 1'b1, fired: 1'b0};
        else        det_q <= det_d;
    end

    assign fired_o = det_q.fired;

    assert_single_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_q.fired) |-> $past(det_q.armed));

    assert_fire_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q.fired && !rearm_i) |=> det_q.fired);
endmodule

// File: rtl/clkseq_timer.sv
`timescale 1ns/1ps
module clkseq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = load_val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/clkgen_powerup_seq.sv
`timescale 1ns/1ps
module clkgen_powerup_seq
    import clkseq_pkg::*;
#(
    parameter int REF_KHZ    = 14318,
    parameter int PG_DLY_US  = 250,
    parameter int SETTLE_US  = 1146,
    parameter int FS_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            supply_ok_i,
    input  logic            pwrgd_n_i,
    input  logic [FS_W-1:0] fs_strap_i,
    output logic [FS_W-1:0] fs_sel_o,
    output logic            osc_en_o,
    output logic            out_en_o,
    output logic [1:0]      state_o
);
    localparam int PG_CYC     = us_to_cycles(REF_KHZ, PG_DLY_US);
    localparam int SETTLE_CYC = us_to_cycles(REF_KHZ, SETTLE_US);
    localparam int MAX_CYC    = (PG_CYC > SETTLE_CYC) ? PG_CYC : SETTLE_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PG_LOAD     = CNT_W'(PG_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e      state;
        logic            run;
        logic [FS_W-1:0] fs;
        logic            osc_en;
        logic            out_en;
    } seq_t;

    seq_t r_d, r_q;

    logic             pg_sync;
    logic             pg_fired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    clkseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pwrgd_n_i),
        .q_o   (pg_sync)
    );

    clkseq_fall_once i_pgdet (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pg_sync),
        .rearm_i (!supply_ok_i),
        .fired_o (pg_fired)
    );

    clkseq_timer #(.W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!supply_ok_i) begin
            r_d.state = ST_OFF;
            r_d.run   = 1'b0;
            r_d.fs    = '0;
            tmr_load  = 1'b1;
        end else begin
            case (r_q.state)
                ST_OFF: r_d.state = ST_WAIT;
                ST_WAIT: begin
                    if (!r_q.run) begin
                        if (pg_fired) begin
                            r_d.run  = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = PG_LOAD;
                        end
                    end else if (tmr_zero) begin
                        r_d.state = ST_SAMPLE;
                        r_d.run   = 1'b0;
                        r_d.fs    = fs_strap_i;
                        tmr_load  = 1'b1;
                        tmr_val   = SETTLE_LOAD;
                    end
                end
                ST_SAMPLE: if (tmr_zero) r_d.state = ST_RUN;
                ST_RUN: ;
                default: r_d.state = ST_OFF;
            endcase
        end
        r_d.osc_en = (r_d.state != ST_OFF);
        r_d.out_en = (r_d.state == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_OFF, run: 1'b0, fs: '0, osc_en: 1'b0, out_en: 1'b0};
        else        r_q <= r_d;
    end

    assign fs_sel_o = r_q.fs;
    assign osc_en_o = r_q.osc_en;
    assign out_en_o = r_q.out_en;
    assign state_o  = r_q.state;

    assert_outen_after_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.out_en) |-> ($past(r_q.state) == ST_SAMPLE));

    assert_supply_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (r_q.state == ST_OFF && !r_q.out_en && !r_q.osc_en && r_q.fs == '0));

    assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && supply_ok_i) |=> (r_q.state == ST_RUN));

    assert_fs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_SAMPLE || r_q.state == ST_RUN) && supply_ok_i) |=> $stable(r_q.fs));

    assert_sample_needs_pg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SAMPLE && $past(r_q.state) == ST_WAIT) |-> pg_fired);

    assert_settle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SAMPLE && supply_ok_i && !tmr_zero) |=> (r_q.state == ST_SAMPLE));
endmodule

// File: tb/test_clkgen_powerup_seq.sv
`timescale 1ns/1ps
module test_clkgen_powerup_seq;
    localparam int KHZ        = 40;
    localparam int PG_EXP     = (KHZ * 250 + 999) / 1000;
    localparam int SETTLE_EXP = (KHZ * 1146 + 999) / 1000;

    // bits [4:1] strap value, bit [0] toggle power-good during the delay
    localparam logic [4:0] VECS [4] = '{5'b0101_0, 5'b1010_1, 5'b1111_0, 5'b0011_1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       pwrgd_n = 1'b1;
    logic [3:0] fs_strap = 4'h0;
    logic [3:0] fs_sel;
    logic       osc_en, out_en;
    logic [1:0] state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    clkgen_powerup_seq #(.REF_KHZ(KHZ)) i_clkgen_powerup_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok),
        .pwrgd_n_i   (pwrgd_n),
        .fs_strap_i  (fs_strap),
        .fs_sel_o    (fs_sel),
        .osc_en_o    (osc_en),
        .out_en_o    (out_en),
        .state_o     (state)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic supply_off();
        @(negedge clk);
        supply_ok = 1'b0;
        pwrgd_n   = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R9 state after supply loss", state, 0);
        check_eq("R9 select cleared", fs_sel, 0);
        check_eq("R9 oscillator off", osc_en, 0);
    endtask

    // returns posedges from power-good fall until state 2 is seen
    task automatic wait_s2(input bit glitch, output int n);
        n = 0;
        while (state != 2'd2 && n < 500) begin
            @(negedge clk);
            n++;
            if (state == 2'd3) check_eq("R7 no run before sample", state, 2);
            if (glitch && n == 6) pwrgd_n = 1'b1;
            if (glitch && n == 8) pwrgd_n = 1'b0;
        end
    endtask

    task automatic power_cycle(input logic [3:0] fs, input bit glitch);
        int n;
        int m;
        supply_off();
        supply_ok = 1'b1;
        fs_strap  = fs;
        @(negedge clk);
        check_eq("R2 state 1 after supply", state, 1);
        check_eq("R2 oscillator on", osc_en, 1);
        repeat (20) @(negedge clk);
        check_eq("R3 held in state 1", state, 1);
        check_eq("R7 outputs off in state 1", out_en, 0);
        pwrgd_n = 1'b0;
        wait_s2(glitch, n);
        check_rng(glitch ? "R8 R4 delay with toggles" : "R4 power-good delay", n, PG_EXP, PG_EXP + 5);
        check_eq("R7 outputs off in state 2", out_en, 0);
        check_eq("R5 select captured", fs_sel, fs);
        fs_strap = ~fs;
        m = 1;
        while (state == 2'd2 && m < 1000) begin
            @(negedge clk);
            if (state == 2'd2) m++;
        end
        check_eq("R6 settle length", m, SETTLE_EXP);
        check_eq("R6 run state", state, 3);
        check_eq("R7 outputs on in state 3", out_en, 1);
        check_eq("R5 select held after strap change", fs_sel, fs);
        repeat (6) begin
            @(negedge clk);
            pwrgd_n = ~pwrgd_n;
        end
        repeat (3) @(negedge clk);
        check_eq("R8 state after toggles", state, 3);
        check_eq("R8 outputs after toggles", out_en, 1);
        check_eq("R8 select after toggles", fs_sel, fs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        int n;
        supply_ok = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1 reset state", state, 0);
        check_eq("R1 reset osc", osc_en, 0);
        check_eq("R1 reset out_en", out_en, 0);
        check_eq("R1 reset select", fs_sel, 0);
        supply_ok = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) begin
            @(negedge clk);
            pwrgd_n = ~pwrgd_n;
        end
        pwrgd_n = 1'b1;
        check_eq("R2 stays off without supply", state, 0);
        check_eq("R2 oscillator off without supply", osc_en, 0);

        for (int i = 0; i < 4; i++) power_cycle(VECS[i][4:1], VECS[i][0]);

        // R10: power-good already low when the supply returns
        @(negedge clk);
        pwrgd_n   = 1'b0;
        supply_ok = 1'b0;
        repeat (5) @(negedge clk);
        fs_strap  = 4'h9;
        supply_ok = 1'b1;
        wait_s2(1'b0, n);
        check_rng("R10 low level counts as fall", n, PG_EXP, PG_EXP + 5);

        // R9: supply lost during the settling interval
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check_eq("R9 state off after mid-settle loss", state, 0);
        check_eq("R9 outputs off after mid-settle loss", out_en, 0);
        check_eq("R9 select cleared after mid-settle loss", fs_sel, 0);
        check_eq("R9 oscillator off after mid-settle loss", osc_en, 0);

        // R9 re-arm: full cycle after the loss still needs a new power-good
        power_cycle(4'h6, 1'b0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule